// File: doc/BRIEF.md
# Write-Only Serial Control Register Receiver

This block is a receive-only slave on a two-wire serial bus (I2C). It loads a small bank of five 5-bit control registers: mode, diagnostic control, fault mask and two volume codes. The controller sends one write frame per register update. The frame carries a 7-bit device address with the direction bit, then one data byte. In the data byte, the top three bits choose the target register and the low five bits are the new value. The block never drives read data. It only pulls the data line low for acknowledge slots, through an open-drain style enable.

Both bus lines are oversampled by the system clock. A register update shows up as a new value on the register outputs, together with a one-cycle strobe on the bit for that register. An external busy input marks the power-up self-test window. Writes that arrive during that window are held back, and they are applied in the first cycle after the window ends.

Top module: `i2c_ctrl_regbank`

## Requirements
- R1: The device address is 1111100 when `addr_sel` is 0 and 1111101 when it is 1. An address byte with any other 7-bit address is not acknowledged, and no register changes.
- R2: A frame whose direction bit (bit 0 of the address byte) is 1 is never acknowledged, even when the address matches. No register changes.
- R3: A START is the data line falling while the clock line is high. A STOP is the data line rising while the clock line is high. Bytes are received MSB first, with each bit taken on the rising clock edge.
- R4: After a matching write address, and again after the data byte, `sda_oe` is 1 while the clock line is high in the ninth clock. It rises only while the clock line is low.
- R5: Data byte bits [7:5] select the register: 000 mode, 001 diagnostic, 010 fault mask, 101 volume 1, 100 volume 2. Bits [4:0] are written to that register. The strobe bit `wr_stb[0..4]` (mode, diagnostic, mask, volume 1, volume 2) is high for exactly one cycle, in the same cycle that the register output takes its new value.
- R6: A data byte whose select code is 011, 110 or 111 is acknowledged. It changes no register and raises no strobe.
- R7: Only the first data byte of a frame is used. A further byte in the same frame is not acknowledged and changes nothing.
- R8: While `init_busy` is 1, writes are acknowledged but not applied, and no strobe fires. In the first cycle after `init_busy` falls, each held register takes its most recently received value, and all of their strobes fire together.
- R9: A START or STOP that arrives before all 8 bits of a data byte have been received abandons the frame without touching any register. After a repeated START, a new address phase begins.
- R10: After reset, all register outputs are 0, `sda_oe` is 0 and `wr_stb` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls the data line low (acknowledge) |
| addr_sel | input | 1 | Sets address bit 0 |
| init_busy | input | 1 | Power-up self-test running; writes are held |
| mode_q | output | 5 | Mode control register |
| diag_q | output | 5 | Diagnostic control register |
| fmask_q | output | 5 | Fault mask register |
| vol1_q | output | 5 | Volume code, channel 1 |
| vol2_q | output | 5 | Volume code, channel 2 |
| wr_stb | output | 5 | One-cycle update strobe per register |

## Verification
A wrong bit counter or state in the receiver shows up on the bus within the same frame. The acknowledge lands on the wrong clock, or is missing, or is given to a read or to a foreign address, and the next acknowledge sample shows it. A wrong select decode or a bad hold buffer shows up only after the STOP or after `init_busy` falls: the wrong output register changes, or the strobe count differs by one. Each frame is therefore followed by a compare of all five outputs and of the per-register strobe counts.

// File: rtl/i2c_rb_pkg.sv
// Shared constants and types for the write-only serial register receiver.
// Assumes a single data byte per frame: 3-bit select plus 5-bit payload.
package i2c_rb_pkg;
    localparam int NUM_REGS  = 5;
    localparam int PAYLOAD_W = 5;
    localparam int SEL_W     = 3;
    localparam int BYTE_W    = PAYLOAD_W + SEL_W;
    localparam int ADDR_W    = 7;

    // Select codes, indexed by strobe bit position: mode, diag, mask, vol1, vol2
    localparam logic [SEL_W-1:0] REG_SEL [NUM_REGS] = '{3'b000, 3'b001, 3'b010, 3'b101, 3'b100};

    typedef enum logic [2:0] {
        LK_IDLE,
        LK_ADDR,
        LK_ADDR_END,
        LK_ADDR_ACK,
        LK_DATA,
        LK_DATA_END,
        LK_DATA_ACK,
        LK_WAIT
    } link_state_e;
endpackage

// File: rtl/i2c_rb_sync.sv
// Two-flop synchronizer for asynchronous bus lines.
// Assumes lines idle high; reset value is a parameter.
module i2c_rb_sync #(
    parameter int         W       = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_r;

    // Two flop stages per line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_r <= RST_VAL;
            q_o    <= RST_VAL;
        end else begin
            meta_r <= d_i;
            q_o    <= meta_r;
        end
    end
endmodule

// File: rtl/i2c_rb_link.sv
// Bus framing: START/STOP detection, byte shifting, address match and
// acknowledge control. Emits one pulse with the first data byte of a frame.
// Assumes synchronized line inputs; the clock line is never stretched.
module i2c_rb_link
    import i2c_rb_pkg::*;
#(
    parameter logic [ADDR_W-2:0] DEV_ADDR_HI = 6'b111110
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic              addr_sel,
    output logic              sda_oe,
    output logic              byte_vld,
    output logic [BYTE_W-1:0] byte_q
);
    localparam int CNT_W = $clog2(BYTE_W);

    link_state_e       state;
    logic              scl_p, sda_p;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] shreg;

    logic scl_rise, scl_fall, start_det, stop_det, addr_hit;

    // Line events from current and previous synchronized samples
    always_comb begin
        scl_rise  = scl_s & ~scl_p;
        scl_fall  = ~scl_s & scl_p;
        start_det = scl_s & scl_p & sda_p & ~sda_s;
        stop_det  = scl_s & scl_p & ~sda_p & sda_s;
        addr_hit  = (shreg[BYTE_W-1:1] == {DEV_ADDR_HI, addr_sel}) && !shreg[0];
    end

    // Frame state machine, shift register and acknowledge driver
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= LK_IDLE;
            scl_p    <= 1'b1;
            sda_p    <= 1'b1;
            bit_cnt  <= '0;
            shreg    <= '0;
            sda_oe   <= 1'b0;
            byte_vld <= 1'b0;
            byte_q   <= '0;
        end else begin
            scl_p    <= scl_s;
            sda_p    <= sda_s;
            byte_vld <= 1'b0;
            if (start_det) begin
                state   <= LK_ADDR;
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
            end else if (stop_det) begin
                state  <= LK_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    LK_ADDR, LK_DATA: begin
                        if (scl_rise) begin
                            shreg   <= {shreg[BYTE_W-2:0], sda_s};
                            bit_cnt <= bit_cnt + 1'b1;
                            if (bit_cnt == CNT_W'(BYTE_W - 1))
                                state <= (state == LK_ADDR) ? LK_ADDR_END : LK_DATA_END;
                        end
                    end
                    LK_ADDR_END: begin
                        if (scl_fall) begin
                            if (addr_hit) begin
                                sda_oe <= 1'b1;
                                state  <= LK_ADDR_ACK;
                            end else begin
                                state <= LK_WAIT;
                            end
                        end
                    end
                    LK_ADDR_ACK: begin
                        if (scl_fall) begin
                            sda_oe  <= 1'b0;
                            bit_cnt <= '0;
                            state   <= LK_DATA;
                        end
                    end
                    LK_DATA_END: begin
                        if (scl_fall) begin
                            sda_oe   <= 1'b1;
                            byte_vld <= 1'b1;
                            byte_q   <= shreg;
                            state    <= LK_DATA_ACK;
                        end
                    end
                    LK_DATA_ACK: begin
                        if (scl_fall) begin
                            sda_oe <= 1'b0;
                            state  <= LK_WAIT;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R2: an address acknowledge never follows a read request
    assert_no_read_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == LK_ADDR_ACK && $past(state) == LK_ADDR_END) |-> !shreg[0]);

    // R4: the acknowledge driver only engages while the clock line is low
    assert_ack_scl_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_s);

    // R7: a data byte is delivered only on entry into the data acknowledge
    assert_one_byte_R7: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld |-> state == LK_DATA_ACK);
endmodule

// File: rtl/i2c_rb_regs.sv
// Register bank: decodes the select field, holds writes during the
// power-up self-test window and drives per-register update strobes.
// Assumes byte_vld is a single-cycle pulse.
module i2c_rb_regs
    import i2c_rb_pkg::*;
(
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 init_busy,
    input  logic                                 byte_vld,
    input  logic [BYTE_W-1:0]                    byte_d,
    output logic [NUM_REGS-1:0][PAYLOAD_W-1:0]   reg_q,
    output logic [NUM_REGS-1:0]                  wr_stb
);
    logic [SEL_W-1:0]     sel;
    logic [PAYLOAD_W-1:0] payload;

    // Split the received byte into select and payload fields
    always_comb begin
        sel     = byte_d[BYTE_W-1:PAYLOAD_W];
        payload = byte_d[PAYLOAD_W-1:0];
    end

    for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_reg
        logic                 hit;
        logic                 pend_r;
        logic [PAYLOAD_W-1:0] pend_val_r;
        logic [PAYLOAD_W-1:0] val_r;
        logic                 stb_r;

        // Decode the select field for this register
        always_comb hit = byte_vld && (sel == REG_SEL[gi]);

        // Apply, hold or flush a write for this register
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend_r     <= 1'b0;
                pend_val_r <= '0;
                val_r      <= '0;
                stb_r      <= 1'b0;
            end else begin
                stb_r <= 1'b0;
                if (init_busy) begin
                    if (hit) begin
                        pend_r     <= 1'b1;
                        pend_val_r <= payload;
                    end
                end else if (hit) begin
                    val_r  <= payload;
                    stb_r  <= 1'b1;
                    pend_r <= 1'b0;
                end else if (pend_r) begin
                    val_r  <= pend_val_r;
                    stb_r  <= 1'b1;
                    pend_r <= 1'b0;
                end
            end
        end

        assign reg_q[gi]  = val_r;
        assign wr_stb[gi] = stb_r;
    end

    // R8: no register update while the self-test window is open
    assert_hold_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        init_busy |=> wr_stb == '0);

    // R5: a register value moves only together with its strobe
    assert_stable_no_stb_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb == '0) |-> $stable(reg_q));
endmodule

// File: rtl/i2c_ctrl_regbank.sv
// Top level of the write-only serial control register receiver.
// Assumes the system clock is at least 20x the bus clock rate.
module i2c_ctrl_regbank
    import i2c_rb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    input  logic       addr_sel,
    input  logic       init_busy,
    output logic [4:0] mode_q,
    output logic [4:0] diag_q,
    output logic [4:0] fmask_q,
    output logic [4:0] vol1_q,
    output logic [4:0] vol2_q,
    output logic [4:0] wr_stb
);
    logic [1:0]                            line_s;
    logic                                  byte_vld;
    logic [BYTE_W-1:0]                     byte_q;
    logic [NUM_REGS-1:0][PAYLOAD_W-1:0]    reg_q;

    i2c_rb_sync #(.W(2), .RST_VAL(2'b11)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({scl_i, sda_i}),
        .q_o   (line_s)
    );

    i2c_rb_link #(.DEV_ADDR_HI(6'b111110)) link_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_s    (line_s[1]),
        .sda_s    (line_s[0]),
        .addr_sel (addr_sel),
        .sda_oe   (sda_oe),
        .byte_vld (byte_vld),
        .byte_q   (byte_q)
    );

    i2c_rb_regs regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .init_busy (init_busy),
        .byte_vld  (byte_vld),
        .byte_d    (byte_q),
        .reg_q     (reg_q),
        .wr_stb    (wr_stb)
    );

    // Unpack register outputs in strobe order
    always_comb begin
        mode_q  = reg_q[0];
        diag_q  = reg_q[1];
        fmask_q = reg_q[2];
        vol1_q  = reg_q[3];
        vol2_q  = reg_q[4];
    end
endmodule

// File: tb/i2c_ctrl_regbank_tb.sv
// Directed bench: a bus master model drives frames and each scenario task
// checks acknowledges, register outputs and strobe counts.
module i2c_ctrl_regbank_tb_top;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       m_low = 1'b0;
    logic       addr_sel = 1'b0;
    logic       init_busy = 1'b0;
    logic       sda_oe;
    logic       sda_bus;
    logic [4:0] mode_q, diag_q, fmask_q, vol1_q, vol2_q, wr_stb;

    assign sda_bus = ~(m_low | sda_oe);

    i2c_ctrl_regbank dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe(sda_oe),
        .addr_sel(addr_sel), .init_busy(init_busy),
        .mode_q(mode_q), .diag_q(diag_q), .fmask_q(fmask_q),
        .vol1_q(vol1_q), .vol2_q(vol2_q), .wr_stb(wr_stb)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    int stb_cnt [5];
    logic [4:0] exp_reg [5];
    int exp_cnt [5];

    // Count strobe cycles per register
    always @(posedge clk) begin
        for (int i = 0; i < 5; i++) if (rst_n && wr_stb[i]) stb_cnt[i]++;
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [4:0] reg_out(input int i);
        case (i)
            0: return mode_q;
            1: return diag_q;
            2: return fmask_q;
            3: return vol1_q;
            default: return vol2_q;
        endcase
    endfunction

    task automatic check_bank(input string req);
        for (int i = 0; i < 5; i++) begin
            check(req, $sformatf("reg%0d value", i), reg_out(i), exp_reg[i]);
            check(req, $sformatf("reg%0d strobes", i), stb_cnt[i], exp_cnt[i]);
        end
    endtask

    task automatic bus_start;
        m_low = 1'b0; #640; scl = 1'b1; #640; m_low = 1'b1; #640; scl = 1'b0; #640;
    endtask

    task automatic bus_stop;
        m_low = 1'b1; #640; scl = 1'b1; #640; m_low = 1'b0; #1280;
    endtask

    task automatic bus_bit(input bit b);
        m_low = ~b; #640; scl = 1'b1; #1280; scl = 1'b0; #640;
    endtask

    task automatic bus_ack(output bit acked);
        m_low = 1'b0; #640; scl = 1'b1; #640;
        acked = !sda_bus;
        if (acked) check("R4", "oe during ack", sda_oe, 1);
        #640; scl = 1'b0; #640;
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) bus_bit(b[i]);
        bus_ack(acked);
    endtask

    task automatic frame(input logic [6:0] a, input bit rw, input logic [7:0] d,
                         output bit a_ack, output bit d_ack);
        bus_start;
        send_byte({a, rw}, a_ack);
        d_ack = 1'b0;
        if (a_ack) send_byte(d, d_ack);
        bus_stop;
    endtask

    task automatic put(input int idx, input logic [4:0] v);
        exp_reg[idx] = v;
        exp_cnt[idx]++;
    endtask

    task automatic t_reset;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check("R10", "oe after reset", sda_oe, 0);
        check("R10", "strobes after reset", wr_stb, 0);
        check_bank("R10");
        rst_n = 1'b1;
        #2000;
    endtask

    task automatic t_basic_write;
        bit a, d;
        frame(7'b1111100, 1'b0, 8'b000_10101, a, d);
        check("R1", "addr ack", a, 1);
        check("R4", "data ack", d, 1);
        put(0, 5'h15);
        check_bank("R5 R3");
    endtask

    task automatic t_all_regs;
        bit a, d;
        frame(7'b1111100, 1'b0, 8'b101_11111, a, d); put(3, 5'h1F);
        frame(7'b1111100, 1'b0, 8'b100_00011, a, d); put(4, 5'h03);
        frame(7'b1111100, 1'b0, 8'b001_01010, a, d); put(1, 5'h0A);
        frame(7'b1111100, 1'b0, 8'b010_10001, a, d); put(2, 5'h11);
        check("R5", "last data ack", d, 1);
        check_bank("R5");
    endtask

    task automatic t_addr_select;
        bit a, d;
        addr_sel = 1'b1;
        frame(7'b1111100, 1'b0, 8'b000_00001, a, d);
        check("R1", "foreign addr nack", a, 0);
        check_bank("R1");
        frame(7'b1111101, 1'b0, 8'b000_00110, a, d);
        check("R1", "addr_sel=1 ack", a, 1);
        put(0, 5'h06);
        check_bank("R1");
        addr_sel = 1'b0;
    endtask

    task automatic t_read_rejected;
        bit a, d;
        frame(7'b1111100, 1'b1, 8'b000_11111, a, d);
        check("R2", "read nack", a, 0);
        check_bank("R2");
    endtask

    task automatic t_unused_code;
        bit a, d;
        frame(7'b1111100, 1'b0, 8'b011_11111, a, d);
        check("R6", "code 011 ack", d, 1);
        frame(7'b1111100, 1'b0, 8'b111_00000, a, d);
        check("R6", "code 111 ack", d, 1);
        check_bank("R6");
    endtask

    task automatic t_second_byte;
        bit a, d, d2;
        bus_start;
        send_byte({7'b1111100, 1'b0}, a);
        send_byte(8'b101_00100, d);
        send_byte(8'b100_11000, d2);
        bus_stop;
        put(3, 5'h04);
        check("R7", "second byte nack", d2, 0);
        check_bank("R7");
    endtask

    task automatic t_abort;
        bit a, d;
        bus_start;
        send_byte({7'b1111100, 1'b0}, a);
        for (int i = 0; i < 4; i++) bus_bit(1'b1);
        bus_stop;
        check_bank("R9 stop abort");
        bus_start;
        send_byte({7'b1111100, 1'b0}, a);
        for (int i = 0; i < 3; i++) bus_bit(1'b0);
        bus_start;
        send_byte({7'b1111100, 1'b0}, a);
        send_byte(8'b001_10011, d);
        bus_stop;
        check("R9", "ack after repeated start", d, 1);
        put(1, 5'h13);
        check_bank("R9 restart");
    endtask

    task automatic t_hold_during_init;
        bit a, d;
        @(negedge clk) init_busy = 1'b1;
        frame(7'b1111100, 1'b0, 8'b000_00011, a, d);
        check("R8", "ack while busy", d, 1);
        frame(7'b1111100, 1'b0, 8'b000_11110, a, d);
        frame(7'b1111100, 1'b0, 8'b100_00111, a, d);
        check_bank("R8 held");
        @(negedge clk) init_busy = 1'b0;
        @(negedge clk);
        check("R8", "flush strobes", wr_stb, 5'b10001);
        check("R8", "mode latest", mode_q, 5'h1E);
        check("R8", "vol2 applied", vol2_q, 5'h07);
        @(negedge clk);
        check("R8", "strobe one cycle", wr_stb, 0);
        put(0, 5'h1E);
        put(4, 5'h07);
        check_bank("R8");
    endtask

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        for (int i = 0; i < 5; i++) begin
            stb_cnt[i] = 0;
            exp_cnt[i] = 0;
            exp_reg[i] = '0;
        end
        t_reset;
        t_basic_write;
        t_all_regs;
        t_addr_select;
        t_read_rejected;
        t_unused_code;
        t_second_byte;
        t_abort;
        t_hold_during_init;
        done = 1'b1;
        finish_run;
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run;
        end
    end
endmodule